// File: doc/BRIEF.md
# SPI Serial EEPROM Command Engine

This block is the slave side of a serial-flash-style memory device. It sits behind an SPI link (active-low select, serial clock, data in, data out with a separate output enable) and turns framed byte commands into accesses on a simple synchronous byte port to an external memory array of 2^ADDR_W bytes. Bits are taken on rising serial-clock edges and presented on falling edges, most significant bit first. The SPI pins are oversampled by the system clock through a synchronizer, so the serial clock must be several system clocks per half period.

Commands set and clear a write-enable latch, read its status byte, stream bytes out of the array from any start address, and load up to one page (2^PAGE_W bytes) into an internal page latch. When the frame closes cleanly, the latch is programmed during a self-timed cycle of WR_CYCLES system clocks. Protection policy lives outside: a single permission input is checked when a write would be committed. While the cycle runs, only the status byte can be read.

Top module: `spi_eeprom_engine`

## Requirements
- R1: Opcodes (MSB first) are 0x03 read, 0x02 write, 0x06 set write-enable, 0x04 clear write-enable, 0x05 read status, 0x01 write status; any other first byte makes the block ignore the rest of that frame, including later opcodes, and keep SO disabled.
- R2: After reset, no command is accepted until a falling edge of the select has been seen.
- R3: so_oe is low whenever cs_n is high and after reset; output bits change after serial-clock falling edges, MSB first.
- R4: Read and write take a 16-bit address after the opcode whose top 16-ADDR_W bits are ignored; a read returns consecutive bytes while clocks continue, and the last address wraps to 0.
- R5: The write-enable latch (status bit 1) is set when the select rises directly after the 8 bits of opcode 0x06, and is cleared by opcode 0x04.
- R6: A write or status write commits only if the write-enable latch is set and wr_permit is high when the select rises; otherwise memory and status stay unchanged.
- R7: During a write, the low PAGE_W address bits advance and wrap inside the page while the upper bits stay fixed, so later bytes overwrite earlier ones at the same offset.
- R8: A commit happens only if the select rises on a byte boundary after at least one complete data byte; a rise anywhere else, or with no data byte, aborts.
- R9: A commit starts a busy cycle (status bit 0 high) lasting WR_CYCLES clocks; the write-enable latch clears when it ends.
- R10: While busy, every opcode except read status is ignored (a read leaves SO disabled, a clear-enable leaves the latch set); read status still works.
- R11: Write status stores data bits 7, 3 and 2 into the same status positions; status bits 6 to 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | SPI data in |
| so | output | 1 | SPI data out |
| so_oe | output | 1 | Output enable for so |
| wr_permit | input | 1 | External permission to commit writes |
| mem_addr | output | ADDR_W | Array byte address |
| mem_rd_en | output | 1 | Array read strobe, data expected next clock |
| mem_rd_data | input | 8 | Array read data |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wr_data | output | 8 | Array write data |

## Verification
Page loads are tried short and aligned, long enough to wrap past the page end, cut off mid-byte and with no data byte at all, which separates the in-page wrap, the byte-boundary commit rule and the empty-frame abort. Reads are tried across the top-of-array boundary with the ignored upper address bits set, which tells whole-array wrap apart from page wrap and from using the raw 16-bit address. Command frames are also sent while the timed cycle runs, without the enable latch, with permission withheld, and after an unknown opcode, so each gate on a commit is shown to act on its own.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_OPC,
      PH_ADDR,
      PH_RDAT,
      PH_WDAT,
      PH_STAT,
      PH_WSR,
      PH_WEN,
      PH_SKIP
   } phase_e;

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   output logic cs_fall,
   output logic cs_rise,
   output logic sck_rise,
   output logic sck_fall,
   output logic si_s
);

   logic [2:0] pipe [STAGES];
   logic [1:0] last;

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_ee_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= {cs_n, sck, si};
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) last <= '0;
      else        last <= pipe[STAGES-1][2:1];

   assign cs_fall  =  last[1] && !pipe[STAGES-1][2];
   assign cs_rise  = !last[1] &&  pipe[STAGES-1][2];
   assign sck_rise = !last[0] &&  pipe[STAGES-1][1] && !pipe[STAGES-1][2];
   assign sck_fall =  last[0] && !pipe[STAGES-1][1] && !pipe[STAGES-1][2];
   assign si_s     =  pipe[STAGES-1][0];

endmodule

// File: rtl/spi_ee_pgbuf.sv
module spi_ee_pgbuf #(
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [PAGE_W-1:0] wr_idx,
   input  logic [7:0]        wr_data,
   input  logic [PAGE_W-1:0] rd_idx,
   output logic              rd_valid,
   output logic [7:0]        rd_data
);

   localparam int ENTRIES = 1 << PAGE_W;

   logic [ENTRIES-1:0] vld;
   logic [7:0]         dat [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) begin
            vld[e] <= 1'b0;
            dat[e] <= '0;
         end else if (clr) begin
            vld[e] <= 1'b0;
         end else if (wr_en && wr_idx == PAGE_W'(e)) begin
            vld[e] <= 1'b1;
            dat[e] <= wr_data;
         end
   end

   assign rd_valid = vld[rd_idx];
   assign rd_data  = dat[rd_idx];

   // R7
   clr_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr && wr_en));

endmodule

// File: rtl/spi_ee_wtimer.sv
module spi_ee_wtimer #(
   parameter int CYCLES = 1000,
   parameter int CW     = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic [CW-1:0] cnt,
   output logic          done
);

   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         busy <= 1'b0;
         cnt  <= '0;
      end else if (busy) begin
         if (cnt == LAST) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end else if (start) begin
         busy <= 1'b1;
         cnt  <= '0;
      end

   assign done = busy && (cnt == LAST);

   // R9
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);

   // R9
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(cnt) == LAST);

endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
   import spi_ee_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int PAGE_W      = 5,
   parameter int WR_CYCLES   = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sck,
   input  logic              si,
   output logic              so,
   output logic              so_oe,
   input  logic              wr_permit,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd_en,
   input  logic [7:0]        mem_rd_data,
   output logic              mem_wr_en,
   output logic [7:0]        mem_wr_data
);

   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int CNT_W      = $clog2(WR_CYCLES + 1);
   localparam int AHI_W      = ADDR_W - 8;
   localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("spi_eeprom_engine: ADDR_W must be 9..16");
   end
   if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
      $error("spi_eeprom_engine: PAGE_W must be 1..ADDR_W-1");
   end
   if (WR_CYCLES < PAGE_BYTES) begin : g_bad_cycles
      $error("spi_eeprom_engine: WR_CYCLES must cover one page");
   end

   logic cs_fall, cs_rise, sck_rise, sck_fall, si_s;

   spi_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .cs_fall(cs_fall), .cs_rise(cs_rise),
      .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
   );

   phase_e            ph;
   logic [2:0]        bc;
   logic [6:0]        sh;
   logic [AHI_W-1:0]  ahi;
   logic [ADDR_W-1:0] addr;
   logic [7:0]        obyte;
   logic              hi_done, is_wr, got, drive, so_q;
   logic              rd_req, rd_pend, kind_sr, wel;
   logic              sr_lock, new_lock;
   logic [1:0]        sr_zone, new_zone;

   logic              busy, tdone, start;
   logic [CNT_W-1:0]  tcnt;
   logic              pg_valid;
   logic [7:0]        pg_data;

   logic [7:0]        byte_in;
   logic              frame_rise, byte_end, commit_ok, pg_clr, pg_wr;
   logic [7:0]        status;

   assign byte_in    = {sh, si_s};
   assign frame_rise = sck_rise && !cs_fall && !cs_rise && (ph != PH_IDLE);
   assign byte_end   = frame_rise && (bc == 3'd7);
   assign status     = {sr_lock, 3'b000, sr_zone, wel, busy};
   assign commit_ok  = !busy && wel && wr_permit && got && (bc == 3'd0) &&
                       (ph == PH_WDAT || ph == PH_WSR);
   assign start      = cs_rise && commit_ok;
   assign pg_clr     = byte_end && (ph == PH_ADDR) && hi_done && is_wr;
   assign pg_wr      = byte_end && (ph == PH_WDAT);

   spi_ee_wtimer #(.CYCLES(WR_CYCLES), .CW(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start),
      .busy(busy), .cnt(tcnt), .done(tdone)
   );

   spi_ee_pgbuf #(.PAGE_W(PAGE_W)) u_page (
      .clk(clk), .rst_n(rst_n), .clr(pg_clr),
      .wr_en(pg_wr), .wr_idx(addr[PAGE_W-1:0]), .wr_data(byte_in),
      .rd_idx(tcnt[PAGE_W-1:0]), .rd_valid(pg_valid), .rd_data(pg_data)
   );

   // frame sequencer
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ph      <= PH_IDLE;
         bc      <= '0;
         sh      <= '0;
         ahi     <= '0;
         addr    <= '0;
         obyte   <= '0;
         hi_done <= 1'b0;
         is_wr   <= 1'b0;
         got     <= 1'b0;
         drive   <= 1'b0;
         so_q    <= 1'b0;
         rd_req  <= 1'b0;
         rd_pend <= 1'b0;
         kind_sr <= 1'b0;
         new_lock <= 1'b0;
         new_zone <= '0;
      end else begin
         rd_req  <= 1'b0;
         rd_pend <= rd_req;
         if (rd_pend) obyte <= mem_rd_data;
         if (cs_fall) begin
            ph      <= PH_OPC;
            bc      <= '0;
            hi_done <= 1'b0;
            is_wr   <= 1'b0;
            got     <= 1'b0;
            drive   <= 1'b0;
         end else if (cs_rise) begin
            if (commit_ok) kind_sr <= (ph == PH_WSR);
            ph    <= PH_IDLE;
            drive <= 1'b0;
         end else begin
            if (sck_fall && (ph == PH_RDAT || ph == PH_STAT)) begin
               so_q  <= obyte[~bc];
               drive <= 1'b1;
            end
            if (frame_rise) begin
               bc <= bc + 3'd1;
               sh <= byte_in[6:0];
               if (ph == PH_WEN) ph <= PH_SKIP;
               if (bc == 3'd7) begin
                  case (ph)
                     PH_OPC: begin
                        case (byte_in)
                           OP_READ:  ph <= busy ? PH_SKIP : PH_ADDR;
                           OP_WRITE: begin
                              ph    <= busy ? PH_SKIP : PH_ADDR;
                              is_wr <= 1'b1;
                           end
                           OP_WREN:  ph <= busy ? PH_SKIP : PH_WEN;
                           OP_RDSR:  begin
                              ph    <= PH_STAT;
                              obyte <= status;
                           end
                           OP_WRSR:  ph <= busy ? PH_SKIP : PH_WSR;
                           default:  ph <= PH_SKIP;
                        endcase
                     end
                     PH_ADDR: begin
                        if (!hi_done) begin
                           hi_done <= 1'b1;
                           ahi     <= byte_in[AHI_W-1:0];
                        end else begin
                           addr <= {ahi, byte_in};
                           if (is_wr) begin
                              ph <= PH_WDAT;
                           end else begin
                              ph     <= PH_RDAT;
                              rd_req <= 1'b1;
                           end
                        end
                     end
                     PH_RDAT: begin
                        addr   <= addr + ADDR_W'(1);
                        rd_req <= 1'b1;
                     end
                     PH_WDAT: begin
                        addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
                        got              <= 1'b1;
                     end
                     PH_STAT: obyte <= status;
                     PH_WSR: begin
                        new_lock <= byte_in[7];
                        new_zone <= byte_in[3:2];
                        got      <= 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
         end
      end

   // write-enable latch and stored status bits
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wel     <= 1'b0;
         sr_lock <= 1'b0;
         sr_zone <= '0;
      end else begin
         if (tdone) begin
            wel <= 1'b0;
            if (kind_sr) begin
               sr_lock <= new_lock;
               sr_zone <= new_zone;
            end
         end else if (cs_rise && ph == PH_WEN) begin
            wel <= 1'b1;
         end else if (byte_end && ph == PH_OPC && byte_in == OP_WRDI && !busy) begin
            wel <= 1'b0;
         end
      end

   assign so          = so_q;
   assign so_oe       = !cs_n && drive;
   assign mem_rd_en   = rd_req;
   assign mem_addr    = busy ? {addr[ADDR_W-1:PAGE_W], tcnt[PAGE_W-1:0]} : addr;
   assign mem_wr_en   = busy && !kind_sr && (tcnt < PAGE_CNT) && pg_valid;
   assign mem_wr_data = pg_data;

   // R10
   rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> !busy);

   // R9
   wel_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !wel);

   // R8
   commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cs_rise));

   // R6
   commit_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(wel) && $past(wr_permit)));

endmodule

// File: tb/spi_eeprom_engine_test.sv
module spi_eeprom_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 6;
   localparam int WR         = 2000;
   localparam int AW         = 13;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cs_n, sck, si, so, so_oe, wr_permit;
   logic [AW-1:0] mem_addr;
   logic          mem_rd_en, mem_wr_en;
   logic [7:0]    mem_rd_data = 8'h00;
   logic [7:0]    mem_wr_data;

   int checks = 0;
   int fails  = 0;
   logic oe_seen = 1'b0;
   logic [7:0] rbuf [64];
   logic [7:0] wbuf [64];
   logic [7:0] mem  [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_eeprom_engine #(.ADDR_W(AW), .PAGE_W(5), .WR_CYCLES(WR)) uut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
      .so(so), .so_oe(so_oe), .wr_permit(wr_permit),
      .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
      .mem_wr_en(mem_wr_en), .mem_wr_data(mem_wr_data)
   );

   function automatic logic [7:0] dflt(input int a);
      return 8'(a) ^ 8'h5A;
   endfunction

   always @(posedge clk) begin
      if (mem_wr_en) mem[int'(mem_addr)] = mem_wr_data;
      if (mem_rd_en)
         mem_rd_data <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : dflt(int'(mem_addr));
   end

   always @(negedge clk) if (so_oe) oe_seen = 1'b1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bit_x(input logic b, output logic r);
      si = b;
      repeat (HALF) @(negedge clk);
      r = so;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_x(tx[i], r);
         rx[i] = r;
      end
   endtask

   task automatic sel();
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic desel();
      repeat (3) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] d;
      sel(); xfer(op, d); desel();
   endtask

   task automatic rdsr(output logic [7:0] st);
      logic [7:0] d;
      sel(); xfer(8'h05, d); xfer(8'h00, st); desel();
   endtask

   task automatic read_n(input logic [15:0] a, input int n);
      logic [7:0] d;
      sel();
      xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
      for (int i = 0; i < n; i++) begin
         xfer(8'h00, d);
         rbuf[i] = d;
      end
      desel();
   endtask

   task automatic write_n(input logic [15:0] a, input int n);
      logic [7:0] d;
      sel();
      xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
      for (int i = 0; i < n; i++) xfer(wbuf[i], d);
      desel();
   endtask

   task automatic wait_idle(input string tag);
      logic [7:0] st;
      rdsr(st);
      for (int k = 0; k < 40 && st[0]; k++) rdsr(st);
      chk(tag, {31'd0, st[0]}, 32'd0);
   endtask

   task automatic t_reset();
      logic [7:0] d, st;
      chk("R3 so_oe after reset", {31'd0, so_oe}, 32'd0);
      chk("R3 mem_wr_en after reset", {31'd0, mem_wr_en}, 32'd0);
      // R2: select already low at reset, clock in a set-enable opcode
      xfer(8'h06, d);
      desel();
      rdsr(st);
      chk("R2 no command before select fall", {24'd0, st}, 32'h00);
      chk("R3 so_oe low once deselected", {31'd0, so_oe}, 32'd0);
   endtask

   task automatic t_enable();
      logic [7:0] st;
      cmd(8'h06);
      oe_seen = 1'b0;
      rdsr(st);
      chk("R5 set-enable", {24'd0, st}, 32'h02);
      chk("R3 SO driven during status read", {31'd0, oe_seen}, 32'd1);
      cmd(8'h04);
      rdsr(st);
      chk("R5 clear-enable", {24'd0, st}, 32'h00);
   endtask

   task automatic t_no_latch();
      logic [7:0] st;
      wbuf[0] = 8'h11;
      write_n(16'h0100, 1);
      rdsr(st);
      chk("R6 no commit without latch", {24'd0, st}, 32'h00);
      read_n(16'h0100, 1);
      chk("R6 memory untouched", {24'd0, rbuf[0]}, {24'd0, dflt(32'h100)});
   endtask

   task automatic t_page_write();
      logic [7:0] st;
      cmd(8'h06);
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      write_n(16'h0123, 3);
      rdsr(st);
      chk("R9 busy and latch during cycle", {24'd0, st}, 32'h03);
      wait_idle("R9 cycle ends");
      rdsr(st);
      chk("R9 latch cleared at end", {24'd0, st}, 32'h00);
      read_n(16'h0123, 3);
      for (int i = 0; i < 3; i++)
         chk("R4 read back written bytes", {24'd0, rbuf[i]}, {24'd0, wbuf[i]});
   endtask

   task automatic t_busy_ignore();
      logic [7:0] st;
      cmd(8'h06);
      wbuf[0] = 8'h77;
      write_n(16'h0200, 1);
      oe_seen = 1'b0;
      read_n(16'h0000, 2);
      chk("R10 read ignored while busy", {31'd0, oe_seen}, 32'd0);
      cmd(8'h04);
      rdsr(st);
      chk("R10 clear-enable ignored, status readable", {24'd0, st}, 32'h03);
      wait_idle("R10 cycle ends");
      read_n(16'h0200, 1);
      chk("R10 pending write landed", {24'd0, rbuf[0]}, 32'h77);
   endtask

   task automatic t_page_wrap();
      logic [7:0] e;
      cmd(8'h06);
      for (int i = 0; i < 34; i++) wbuf[i] = 8'h80 + 8'(i);
      write_n(16'h005E, 34);
      wait_idle("R7 cycle ends");
      read_n(16'h0040, 33);
      for (int o = 0; o < 32; o++) begin
         if (o == 30)      e = 8'hA0;
         else if (o == 31) e = 8'hA1;
         else              e = 8'h80 + 8'(o + 2);
         chk("R7 in-page wrap content", {24'd0, rbuf[o]}, {24'd0, e});
      end
      chk("R7 next page untouched", {24'd0, rbuf[32]}, {24'd0, dflt(32'h60)});
   endtask

   task automatic t_abort();
      logic [7:0] d, st;
      logic r;
      cmd(8'h06);
      sel();
      xfer(8'h02, d); xfer(8'h03, d); xfer(8'h00, d); xfer(8'h99, d);
      for (int i = 0; i < 3; i++) bit_x(1'b0, r);
      desel();
      rdsr(st);
      chk("R8 mid-byte rise aborts", {24'd0, st}, 32'h02);
      sel();
      xfer(8'h02, d); xfer(8'h03, d); xfer(8'h00, d);
      desel();
      rdsr(st);
      chk("R8 no data byte aborts", {24'd0, st}, 32'h02);
      read_n(16'h0300, 1);
      chk("R8 memory untouched", {24'd0, rbuf[0]}, {24'd0, dflt(32'h300)});
      cmd(8'h04);
   endtask

   task automatic t_read_wrap();
      read_n(16'hFFFE, 3);
      chk("R4 read at top", {24'd0, rbuf[0]}, {24'd0, dflt(32'h1FFE)});
      chk("R4 read last address", {24'd0, rbuf[1]}, {24'd0, dflt(32'h1FFF)});
      chk("R4 wrap to zero", {24'd0, rbuf[2]}, {24'd0, dflt(32'h0)});
   endtask

   task automatic t_permit();
      logic [7:0] st;
      wr_permit = 1'b0;
      cmd(8'h06);
      wbuf[0] = 8'h12;
      write_n(16'h0400, 1);
      rdsr(st);
      chk("R6 permission withheld", {24'd0, st}, 32'h02);
      read_n(16'h0400, 1);
      chk("R6 memory untouched", {24'd0, rbuf[0]}, {24'd0, dflt(32'h400)});
      wr_permit = 1'b1;
      cmd(8'h04);
   endtask

   task automatic t_status_write();
      logic [7:0] d, st;
      cmd(8'h06);
      sel(); xfer(8'h01, d); xfer(8'hFF, d); desel();
      wait_idle("R11 cycle ends");
      rdsr(st);
      chk("R11 stored status bits", {24'd0, st}, 32'h8C);
      cmd(8'h06);
      sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
      wait_idle("R11 cycle ends");
      rdsr(st);
      chk("R11 status cleared", {24'd0, st}, 32'h00);
   endtask

   task automatic t_bad_opcode();
      logic [7:0] d, st;
      oe_seen = 1'b0;
      sel();
      xfer(8'hA5, d); xfer(8'h06, d); xfer(8'h05, d); xfer(8'h00, d);
      desel();
      chk("R1 SO stays off after unknown opcode", {31'd0, oe_seen}, 32'd0);
      rdsr(st);
      chk("R1 later opcode in frame ignored", {24'd0, st}, 32'h00);
   endtask

   initial begin
      rst_n = 1'b0; cs_n = 1'b0; sck = 1'b0; si = 1'b0; wr_permit = 1'b1;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_enable();
      t_no_latch();
      t_page_write();
      t_busy_ignore();
      t_page_wrap();
      t_abort();
      t_read_wrap();
      t_permit();
      t_status_write();
      t_bad_opcode();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule